// File: doc/BRIEF.md
# Retimer Channel Training Controller

This block is the control core for one direction of a link retimer. It sits beside the high-speed data path and decides, cycle by cycle, what the transmitter sends and which clock drives it. Its inputs are decoded events from two places. One is the sideband: ordinary transactions, link-parameter broadcasts and the resume command, each tagged with the port it arrived on. The other is the receiver: activity present, a training symbol seen, clock recovery locked, training finished on every segment, and the clock-switch conditions met.

Sideband traffic is relayed to the opposite port one cycle later with its payload untouched. A parameter broadcast is the exception: it is captured into the stored link parameters and sent out of both ports. A resume command moves the lane-initialization tracker into its equalization phase, and only from then on does the channel side answer a received training symbol. The channel state machine waits for receiver activity, then holds in a lock state. In that state it may send its own wake ordered set, tagged with the retimer's chain index, on the local clock. It goes over to the recovered clock and plain bit forwarding only once every switch condition holds at the same time.

Top module: `rtm_retimer_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, tx_src is 0 (idle), clk_recovered is 0 (local clock), wake_id is 0 and neither sideband output is valid.
- R2: Receiver activity while in channel detect moves the machine to lock; tx_src stays 0 until a wake is started.
- R3: In lock, with receiver activity and after a resume command has been seen, a received SLOS symbol makes tx_src 1 (wake) from the next cycle, with wake_id equal to rt_index (1 to 7) and clk_recovered 0.
- R4: A received SLOS symbol before any resume command has been seen is ignored: tx_src stays 0.
- R5: While waking, the machine moves to forwarding only in a cycle where cdr_lock, train_all_done and clk_switch_ok are all 1. If any one of them is 0, tx_src stays 1 and clk_recovered stays 0.
- R6: In forwarding, tx_src is 2 (forward received bits), clk_recovered is 1 and wake_id is 0.
- R7: rx_active at 0 in any state returns the machine to channel detect at the next edge, with tx_src 0 and clk_recovered 0.
- R8: A sideband transaction of kind 0 (other) is relayed one cycle later on the opposite port only, with its data unchanged. sb_from_dn=1 means it arrived on the downstream port and leaves on the upstream one. It does not change link_params.
- R9: A transaction of kind 1 (broadcast) loads its data into link_params and appears one cycle later on both ports with that data.
- R10: A transaction of kind 2 (resume), arriving from either port, is relayed to the opposite port one cycle later and puts the tracker in the equalization phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_index | input | 3 | Static chain index of this retimer, 1 to 7 |
| rx_active | input | 1 | Receiver activity detected |
| rx_slos | input | 1 | Receiver SLOS training symbol seen |
| cdr_lock | input | 1 | Clock/data recovery locked |
| train_all_done | input | 1 | Training complete on all segments |
| clk_switch_ok | input | 1 | Clock-switch conditions hold |
| sb_valid | input | 1 | Decoded sideband transaction present |
| sb_from_dn | input | 1 | 1: arrived on downstream port, 0: upstream |
| sb_kind | input | 2 | 0 other, 1 broadcast, 2 resume |
| sb_data | input | 8 | Transaction payload |
| sb_up_valid | output | 1 | Transaction out of the upstream port |
| sb_up_data | output | 8 | Upstream payload |
| sb_dn_valid | output | 1 | Transaction out of the downstream port |
| sb_dn_data | output | 8 | Downstream payload |
| link_params | output | 8 | Stored link parameters (speed, lanes) |
| tx_src | output | 2 | Transmit source: 0 idle, 1 wake, 2 forward |
| clk_recovered | output | 1 | 1 selects the recovered clock |
| wake_id | output | 3 | Index carried by the wake ordered set |

## Verification
The bench runs every chain index through the whole training path. It tries all seven incomplete combinations of the three switch conditions before the complete one. A design that switched clocks on a partial condition would show tx_src 2 too early. A design that ignored the equalization gate would start waking on a SLOS seen before the resume command. Every sideband kind is sent from both ports. This catches a relay to the wrong port, an echo back onto the source port, and a parameter register that an ordinary transaction can overwrite. Dropping receiver activity while waking and while forwarding catches a machine that keeps the recovered clock after the link is lost.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
   typedef enum logic [1:0] {TX_IDLE = 2'd0, TX_WAKE = 2'd1, TX_FWD = 2'd2} tx_src_e;
   typedef enum logic [1:0] {CH_DETECT = 2'd0, CH_LOCK = 2'd1, CH_FWD = 2'd2} chan_e;
   typedef enum logic [1:0] {PH_INIT = 2'd0, PH_PARAM = 2'd1, PH_EQ = 2'd2} phase_e;
   typedef enum logic [1:0] {SB_OTHER = 2'd0, SB_BCAST = 2'd1, SB_RESUME = 2'd2} sb_kind_e;
endpackage

// File: rtl/rtm_sb_tracker.sv
module rtm_sb_tracker
   import rtm_pkg::*;
#(
   parameter int PW      = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          sb_valid,
   input  logic          sb_from_dn,
   input  logic [1:0]    sb_kind,
   input  logic [PW-1:0] sb_data,
   output logic [1:0]    port_valid,
   output logic [PW-1:0] port_data [2],
   output logic [PW-1:0] params,
   output logic          eq_phase
);
   localparam int NPORT = 2;

   phase_e        phase_q;
   logic          is_bcast, is_resume, is_relay;
   logic [1:0]    v_nxt;

   always_comb begin
      is_bcast  = sb_valid && (sb_kind == SB_BCAST);
      is_resume = sb_valid && (sb_kind == SB_RESUME);
      is_relay  = sb_valid && (sb_kind != SB_BCAST);
      v_nxt[0]  = is_bcast || (is_relay && sb_from_dn);
      v_nxt[1]  = is_bcast || (is_relay && !sb_from_dn);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_INIT;
         params  <= '0;
      end else begin
         if (is_bcast) params <= sb_data;
         if (is_resume) phase_q <= PH_EQ;
         else if (is_bcast && phase_q == PH_INIT) phase_q <= PH_PARAM;
      end
   end

   assign eq_phase = (phase_q == PH_EQ);

   // index 0 = upstream port, index 1 = downstream port
   for (genvar p = 0; p < NPORT; p++) begin : g_port
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               port_valid[p] <= 1'b0;
               port_data[p]  <= '0;
            end else begin
               port_valid[p] <= v_nxt[p];
               port_data[p]  <= v_nxt[p] ? sb_data : '0;
            end
         end
      end else begin : g_comb
         assign port_valid[p] = v_nxt[p];
         assign port_data[p]  = v_nxt[p] ? sb_data : '0;
      end
   end

   if (REG_OUT) begin : g_chk
      p_bcast_both_r9: assert property (@(posedge clk) disable iff (rst)
         (sb_valid && sb_kind == SB_BCAST) |=> (port_valid == 2'b11 &&
            port_data[0] == $past(sb_data) && port_data[1] == $past(sb_data)));
      p_src_quiet_r8: assert property (@(posedge clk) disable iff (rst)
         (sb_valid && sb_kind == SB_OTHER && sb_from_dn) |=> (port_valid == 2'b01));
   end
   p_params_r9: assert property (@(posedge clk) disable iff (rst)
      (sb_valid && sb_kind == SB_BCAST) |=> (params == $past(sb_data)));
   p_resume_eq_r10: assert property (@(posedge clk) disable iff (rst)
      (sb_valid && sb_kind == SB_RESUME) |=> eq_phase);
endmodule

// File: rtl/rtm_chan_fsm.sv
module rtm_chan_fsm
   import rtm_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rt_index,
   input  logic             eq_phase,
   input  logic             rx_active,
   input  logic             rx_slos,
   input  logic             cdr_lock,
   input  logic             train_all_done,
   input  logic             clk_switch_ok,
   output tx_src_e          tx_src,
   output logic             clk_rec,
   output logic [IDX_W-1:0] wake_id
);
   chan_e state_q;
   logic  waking_q;
   logic  switch_ok;

   assign switch_ok = cdr_lock && train_all_done && clk_switch_ok;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= CH_DETECT;
         waking_q <= 1'b0;
      end else if (!rx_active) begin
         state_q  <= CH_DETECT;
         waking_q <= 1'b0;
      end else begin
         unique case (state_q)
            CH_DETECT: begin
               state_q  <= CH_LOCK;
               waking_q <= 1'b0;
            end
            CH_LOCK: begin
               if (!waking_q) begin
                  if (rx_slos && eq_phase) waking_q <= 1'b1;
               end else if (switch_ok) begin
                  state_q  <= CH_FWD;
                  waking_q <= 1'b0;
               end
            end
            default: state_q <= CH_FWD;
         endcase
      end
   end

   always_comb begin
      tx_src  = TX_IDLE;
      clk_rec = 1'b0;
      wake_id = '0;
      if (state_q == CH_FWD) begin
         tx_src  = TX_FWD;
         clk_rec = 1'b1;
      end else if (state_q == CH_LOCK && waking_q) begin
         tx_src  = TX_WAKE;
         wake_id = rt_index;
      end
   end

   p_loss_idle_r7: assert property (@(posedge clk) disable iff (rst)
      !rx_active |=> (tx_src == TX_IDLE && !clk_rec));
   p_switch_cond_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(clk_rec) |-> $past(switch_ok && rx_active));
   p_wake_gate_r4: assert property (@(posedge clk) disable iff (rst)
      (tx_src == TX_WAKE && $past(tx_src) != TX_WAKE) |-> $past(rx_slos && eq_phase));
   p_fwd_from_wake_r6: assert property (@(posedge clk) disable iff (rst)
      (tx_src == TX_FWD && $past(tx_src) != TX_FWD) |-> $past(tx_src) == TX_WAKE);
endmodule

// File: rtl/rtm_retimer_ctrl.sv
module rtm_retimer_ctrl
   import rtm_pkg::*;
#(
   parameter int PW      = 8,
   parameter int IDX_W   = 3,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rt_index,
   input  logic             rx_active,
   input  logic             rx_slos,
   input  logic             cdr_lock,
   input  logic             train_all_done,
   input  logic             clk_switch_ok,
   input  logic             sb_valid,
   input  logic             sb_from_dn,
   input  logic [1:0]       sb_kind,
   input  logic [PW-1:0]    sb_data,
   output logic             sb_up_valid,
   output logic [PW-1:0]    sb_up_data,
   output logic             sb_dn_valid,
   output logic [PW-1:0]    sb_dn_data,
   output logic [PW-1:0]    link_params,
   output logic [1:0]       tx_src,
   output logic             clk_recovered,
   output logic [IDX_W-1:0] wake_id
);
   localparam int MAX_IDX = (1 << IDX_W) - 1;

   if (PW < 1) begin : g_bad_pw
      $error("PW must be at least 1");
   end
   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
      $error("IDX_W must be 1 to 8");
   end

   logic [1:0]    pv;
   logic [PW-1:0] pd [2];
   logic          eq_phase;
   tx_src_e       tx_e;

   rtm_sb_tracker #(.PW(PW), .REG_OUT(REG_OUT)) sb_i (
      .clk(clk), .rst(rst), .sb_valid(sb_valid), .sb_from_dn(sb_from_dn),
      .sb_kind(sb_kind), .sb_data(sb_data), .port_valid(pv), .port_data(pd),
      .params(link_params), .eq_phase(eq_phase));

   rtm_chan_fsm #(.IDX_W(IDX_W)) ch_i (
      .clk(clk), .rst(rst), .rt_index(rt_index), .eq_phase(eq_phase),
      .rx_active(rx_active), .rx_slos(rx_slos), .cdr_lock(cdr_lock),
      .train_all_done(train_all_done), .clk_switch_ok(clk_switch_ok),
      .tx_src(tx_e), .clk_rec(clk_recovered), .wake_id(wake_id));

   assign sb_up_valid = pv[0];
   assign sb_up_data  = pd[0];
   assign sb_dn_valid = pv[1];
   assign sb_dn_data  = pd[1];
   assign tx_src      = tx_e;

   always_ff @(posedge clk) begin
      if (!rst) begin
         p_index_range_r3: assert (int'(rt_index) >= 1 && int'(rt_index) <= MAX_IDX);
      end
   end
endmodule

// File: tb/rtm_retimer_ctrl_tb_top.sv
module rtm_retimer_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] rt_index = 3'd1;
   logic       rx_active = 0, rx_slos = 0, cdr_lock = 0, train_all_done = 0, clk_switch_ok = 0;
   logic       sb_valid = 0, sb_from_dn = 0;
   logic [1:0] sb_kind = 0;
   logic [7:0] sb_data = 0;
   logic       sb_up_valid, sb_dn_valid, clk_recovered;
   logic [7:0] sb_up_data, sb_dn_data, link_params;
   logic [1:0] tx_src;
   logic [2:0] wake_id;
   int         total = 0, bad = 0;

   rtm_retimer_ctrl dut_i (.*);

   always #5 clk = ~clk;

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1; rx_active = 0; rx_slos = 0; cdr_lock = 0; train_all_done = 0;
      clk_switch_ok = 0; sb_valid = 0;
      step(); step();
      rst = 0;
   endtask

   task automatic send_sb(input logic from_dn, input logic [1:0] kind, input logic [7:0] d);
      sb_valid = 1; sb_from_dn = from_dn; sb_kind = kind; sb_data = d;
      step();
      sb_valid = 0;
   endtask

   initial begin : watchdog
      #1_000_000;
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      do_reset();
      step();
      chk("R1 tx", tx_src, 0);
      chk("R1 clk", clk_recovered, 0);
      chk("R1 id", wake_id, 0);
      chk("R1 sb", {sb_up_valid, sb_dn_valid}, 0);

      for (int idx = 1; idx <= 7; idx++) begin
         do_reset();
         rt_index = 3'(idx);
         rx_active = 1; step();
         chk("R2 lock idle", tx_src, 0);
         rx_slos = 1; step(); rx_slos = 0;
         chk("R4 slos ignored", tx_src, 0);
         send_sb(idx[0], 2'd2, 8'(idx));
         chk("R10 resume relay up", sb_up_valid, idx[0] ? 1 : 0);
         chk("R10 resume relay dn", sb_dn_valid, idx[0] ? 0 : 1);
         rx_slos = 1; step(); rx_slos = 0;
         chk("R3 wake", tx_src, 1);
         chk("R3 id", wake_id, idx);
         chk("R3 clk", clk_recovered, 0);
         for (int m = 0; m < 7; m++) begin
            cdr_lock = m[0]; train_all_done = m[1]; clk_switch_ok = m[2];
            step();
            chk("R5 hold wake", tx_src, 1);
            chk("R5 local clk", clk_recovered, 0);
         end
         cdr_lock = 1; train_all_done = 1; clk_switch_ok = 1;
         step();
         chk("R6 fwd", tx_src, 2);
         chk("R6 clk", clk_recovered, 1);
         chk("R6 id", wake_id, 0);
         step();
         chk("R6 stays fwd", tx_src, 2);
         rx_active = 0; step();
         chk("R7 fwd loss tx", tx_src, 0);
         chk("R7 fwd loss clk", clk_recovered, 0);
         cdr_lock = 0; train_all_done = 0; clk_switch_ok = 0;
      end

      // loss while waking, then restart needs a fresh SLOS
      do_reset();
      rt_index = 3'd5;
      send_sb(1'b0, 2'd2, 8'h00);
      rx_active = 1; step();
      rx_slos = 1; step(); rx_slos = 0;
      chk("R3 wake again", tx_src, 1);
      rx_active = 0; step();
      chk("R7 wake loss", tx_src, 0);
      rx_active = 1; step(); step();
      chk("R7 restart idle", tx_src, 0);

      // sideband sweep
      do_reset();
      send_sb(1'b0, 2'd1, 8'hA5);
      chk("R9 up v", sb_up_valid, 1);
      chk("R9 dn v", sb_dn_valid, 1);
      chk("R9 up d", sb_up_data, 8'hA5);
      chk("R9 dn d", sb_dn_data, 8'hA5);
      chk("R9 params", link_params, 8'hA5);
      for (int f = 0; f < 2; f++) begin
         for (int d = 1; d < 256; d += 37) begin
            send_sb(f[0], 2'd0, 8'(d));
            chk("R8 up v", sb_up_valid, f);
            chk("R8 dn v", sb_dn_valid, 1 - f);
            chk("R8 data", f ? sb_up_data : sb_dn_data, d);
            chk("R8 params kept", link_params, 8'hA5);
            send_sb(f[0], 2'd1, 8'(d + 3));
            chk("R9 both", {sb_up_valid, sb_dn_valid}, 3);
            chk("R9 load", link_params, d + 3);
            chk("R9 data", f ? sb_dn_data : sb_up_data, d + 3);
            send_sb(1'b0, 2'd1, 8'hA5);
         end
      end
      step();
      chk("R8 pulse ends", {sb_up_valid, sb_dn_valid}, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule